// File: doc/BRIEF.md
# Pipelined Cache SRAM Read Sequencer

This block drives read cycles into an external second-level cache built from synchronous SRAMs, with the tag array and the data array addressed side by side. A caller offers a word address on a valid/ready request port. For every accepted request the block drives the tag address (the word address without its sub-line bits) and the data address, together with active-low output enables for both arrays, in the cycle after the accepting edge. A run of reads is simply a series of single reads; each one repeats the whole set of enables and addresses, and there is no separate burst signalling.

The returning tag and data words are taken from the SRAM buses on a fixed edge that depends on a static timing mode. In the three-stage mode the buses are sampled on the third edge after the issue edge, and three reads can be in flight at once. In the two-stage mode the buses are sampled on the second edge after issue, and two reads can be in flight. Both modes accept one request per cycle. Each captured tag and data pair is presented with a one-cycle response-valid pulse, always in issue order. The write strobes of both arrays are held inactive.

Top module: `ecache_rd_seq`

## Requirements
- R1: During and after synchronous reset, both output enables and both write strobes are high, resp_valid_o is low, and req_ready_o is high.
- R2: A request accepted on a rising edge (req_valid_i and req_ready_o high) drives tag_oe_n_o and dat_oe_n_o low for exactly the following cycle, with tag_addr_o equal to req_addr_i[ADDR_W-1:SUB_W] and dat_addr_o equal to req_addr_i; consecutive accepted requests each produce their own low enable cycle and addresses; enables are high in cycles with no accepted request.
- R3: With mode_sel_i = 0 (three-stage mode), a request accepted on edge k has its tag and data sampled from the SRAM buses on edge k+3, and resp_valid_o is high in the cycle after that edge.
- R4: With mode_sel_i = 1 (two-stage mode), a request accepted on edge k has its tag and data sampled on edge k+2, and resp_valid_o is high in the cycle after that edge.
- R5: req_ready_o stays high under back-to-back requests in either mode, and the number of reads in flight never exceeds three in the three-stage mode or two in the two-stage mode.
- R6: tag_we_n_o and dat_we_n_o stay high at all times.
- R7: mode_sel_i takes effect only while no read is in flight; a change while reads are in flight is ignored until the block is idle.
- R8: Each response carries the tag word and the data word of the same request, and responses appear in the order the requests were accepted, one per request.
- R9: A reset asserted while reads are in flight discards them: no response for them appears after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| mode_sel_i | input | 1 | Timing mode: 0 three-stage, 1 two-stage |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Read request can be accepted |
| req_addr_i | input | ADDR_W | Word address of the read |
| tag_oe_n_o | output | 1 | Tag SRAM output enable, active low |
| tag_we_n_o | output | 1 | Tag SRAM write strobe, active low, held high |
| tag_addr_o | output | ADDR_W-SUB_W | Tag SRAM address |
| tag_rdata_i | input | TAG_W | Tag SRAM read data bus |
| dat_oe_n_o | output | 1 | Data SRAM output enable, active low |
| dat_we_n_o | output | 1 | Data SRAM write strobe, active low, held high |
| dat_addr_o | output | ADDR_W | Data SRAM address |
| dat_rdata_i | input | DATA_W | Data SRAM read data bus |
| resp_valid_o | output | 1 | Response valid pulse |
| resp_tag_o | output | TAG_W | Captured tag word |
| resp_data_o | output | DATA_W | Captured data word |

## Verification
A wrong bit in the valid shift register moves the capture by a cycle, so the response either carries the tag and data of a neighbouring address or shows up one cycle early or late; the bench's SRAM model makes every address return a distinct word, so this shows on the first response after the bad issue, two or three cycles later. A wrong in-flight count shows up as req_ready_o dropping during a back-to-back run or as the mode switching while reads are still in flight, which then shifts the capture edge of the remaining reads. A stale valid bit left after reset or after a mode switch shows as a response pulse with no request behind it within three cycles.

// File: rtl/ecrd_pkg.sv
package ecrd_pkg;

    // Static read timing mode, selected by mode_sel_i.
    typedef enum logic {
        RD_PIPE3 = 1'b0,   // three-stage: sample on third edge after issue
        RD_PIPE2 = 1'b1    // two-stage: sample on second edge after issue
    } rd_mode_e;

    localparam int unsigned LAT_PIPE3 = 3;
    localparam int unsigned LAT_PIPE2 = 2;
    localparam int unsigned LAT_MAX   = (LAT_PIPE3 > LAT_PIPE2) ? LAT_PIPE3 : LAT_PIPE2;

    // Issue-to-sample latency in edges for a mode.
    function automatic int unsigned lat_of(rd_mode_e m);
        return (m == RD_PIPE3) ? LAT_PIPE3 : LAT_PIPE2;
    endfunction

endpackage

// File: rtl/ecrd_issue.sv
module ecrd_issue
    import ecrd_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned SUB_W  = 2,
    parameter int unsigned CNT_W  = 2
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    req_valid_i,
    input  logic [ADDR_W-1:0]       req_addr_i,
    input  logic                    mode_sel_i,
    input  logic                    cap_now_i,
    output logic                    req_ready_o,
    output logic                    accept_o,
    output rd_mode_e                mode_eff_o,
    output rd_mode_e                mode_q_o,
    output logic                    tag_oe_n_o,
    output logic [ADDR_W-SUB_W-1:0] tag_addr_o,
    output logic                    dat_oe_n_o,
    output logic [ADDR_W-1:0]       dat_addr_o,
    output logic                    tag_we_n_o,
    output logic                    dat_we_n_o
);

    typedef struct packed {
        rd_mode_e          mode;
        logic [CNT_W-1:0]  cnt;
        logic              tag_oe_n;
        logic              dat_oe_n;
        logic [ADDR_W-1:0] addr;
        logic              tag_we_n;
        logic              dat_we_n;
    } issue_s;

    issue_s           s_d, s_q;
    logic             idle;
    rd_mode_e         mode_eff;
    logic [CNT_W-1:0] lim;
    logic             ready;
    logic             accept;

    always_comb begin
        idle     = (s_q.cnt == '0);
        // The mode input is only honoured while nothing is in flight.
        mode_eff = idle ? rd_mode_e'(mode_sel_i) : s_q.mode;
        lim      = CNT_W'(lat_of(mode_eff));
        // A slot frees on the same edge a capture happens.
        ready    = (s_q.cnt < lim) || cap_now_i;
        accept   = req_valid_i && ready;

        s_d          = s_q;
        s_d.mode     = mode_eff;
        s_d.cnt      = s_q.cnt + CNT_W'(accept) - CNT_W'(cap_now_i);
        s_d.tag_oe_n = !accept;
        s_d.dat_oe_n = !accept;
        if (accept) begin
            s_d.addr = req_addr_i;
        end
        s_d.tag_we_n = 1'b1;
        s_d.dat_we_n = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q.mode     <= RD_PIPE3;
            s_q.cnt      <= '0;
            s_q.tag_oe_n <= 1'b1;
            s_q.dat_oe_n <= 1'b1;
            s_q.addr     <= '0;
            s_q.tag_we_n <= 1'b1;
            s_q.dat_we_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready_o = ready;
    assign accept_o    = accept;
    assign mode_eff_o  = mode_eff;
    assign mode_q_o    = s_q.mode;
    assign tag_oe_n_o  = s_q.tag_oe_n;
    assign dat_oe_n_o  = s_q.dat_oe_n;
    assign tag_addr_o  = s_q.addr[ADDR_W-1:SUB_W];
    assign dat_addr_o  = s_q.addr;
    assign tag_we_n_o  = s_q.tag_we_n;
    assign dat_we_n_o  = s_q.dat_we_n;

    // R5: in-flight count never exceeds the held mode's limit
    a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (rst_i)
        s_q.cnt <= CNT_W'(lat_of(s_q.mode)));

    // R7: while reads are in flight the held mode does not move
    a_r7_mode_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
        (s_q.cnt != '0 && !cap_now_i) |=> (s_q.mode == $past(s_q.mode)));

endmodule

// File: rtl/ecrd_track.sv
module ecrd_track
    import ecrd_pkg::*;
#(
    parameter int unsigned TAG_W  = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = LAT_MAX
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              accept_i,
    input  rd_mode_e          mode_i,
    input  logic [TAG_W-1:0]  tag_bus_i,
    input  logic [DATA_W-1:0] dat_bus_i,
    output logic              cap_now_o,
    output logic              resp_valid_o,
    output logic [TAG_W-1:0]  resp_tag_o,
    output logic [DATA_W-1:0] resp_data_o
);

    localparam int unsigned TAP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0]  vld;
        logic              rv;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } trk_s;

    trk_s             s_d, s_q;
    logic [TAP_W-1:0] tap;
    logic             cap;

    always_comb begin
        tap = TAP_W'(lat_of(mode_i) - 1);
        cap = s_q.vld[tap];

        s_d        = s_q;
        s_d.vld[0] = accept_i;
        // Shift the markers; the one sampled this edge is dropped so a
        // later mode switch cannot see a stale bit further down the line.
        for (int i = 1; i < DEPTH; i++) begin
            s_d.vld[i] = s_q.vld[i-1] && (TAP_W'(i-1) != tap);
        end
        s_d.rv = cap;
        if (cap) begin
            s_d.tag  = tag_bus_i;
            s_d.data = dat_bus_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q.vld  <= '0;
            s_q.rv   <= 1'b0;
            s_q.tag  <= '0;
            s_q.data <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cap_now_o    = cap;
    assign resp_valid_o = s_q.rv;
    assign resp_tag_o   = s_q.tag;
    assign resp_data_o  = s_q.data;

    // R5: markers in the line never outnumber the mode's depth
    a_r5_track_depth: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(s_q.vld) <= lat_of(mode_i));

endmodule

// File: rtl/ecache_rd_seq.sv
module ecache_rd_seq
    import ecrd_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned SUB_W  = 2,
    parameter int unsigned TAG_W  = 12,
    parameter int unsigned DATA_W = 32
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    mode_sel_i,
    input  logic                    req_valid_i,
    output logic                    req_ready_o,
    input  logic [ADDR_W-1:0]       req_addr_i,
    output logic                    tag_oe_n_o,
    output logic                    tag_we_n_o,
    output logic [ADDR_W-SUB_W-1:0] tag_addr_o,
    input  logic [TAG_W-1:0]        tag_rdata_i,
    output logic                    dat_oe_n_o,
    output logic                    dat_we_n_o,
    output logic [ADDR_W-1:0]       dat_addr_o,
    input  logic [DATA_W-1:0]       dat_rdata_i,
    output logic                    resp_valid_o,
    output logic [TAG_W-1:0]        resp_tag_o,
    output logic [DATA_W-1:0]       resp_data_o
);

    localparam int unsigned CNT_W = $clog2(LAT_MAX + 1);

    logic     cap_now;
    logic     accept;
    rd_mode_e mode_eff;
    rd_mode_e mode_q;

    ecrd_issue #(
        .ADDR_W (ADDR_W),
        .SUB_W  (SUB_W),
        .CNT_W  (CNT_W)
    ) i_issue (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .req_valid_i (req_valid_i),
        .req_addr_i  (req_addr_i),
        .mode_sel_i  (mode_sel_i),
        .cap_now_i   (cap_now),
        .req_ready_o (req_ready_o),
        .accept_o    (accept),
        .mode_eff_o  (mode_eff),
        .mode_q_o    (mode_q),
        .tag_oe_n_o  (tag_oe_n_o),
        .tag_addr_o  (tag_addr_o),
        .dat_oe_n_o  (dat_oe_n_o),
        .dat_addr_o  (dat_addr_o),
        .tag_we_n_o  (tag_we_n_o),
        .dat_we_n_o  (dat_we_n_o)
    );

    ecrd_track #(
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W),
        .DEPTH  (LAT_MAX)
    ) i_track (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .accept_i     (accept),
        .mode_i       (mode_eff),
        .tag_bus_i    (tag_rdata_i),
        .dat_bus_i    (dat_rdata_i),
        .cap_now_o    (cap_now),
        .resp_valid_o (resp_valid_o),
        .resp_tag_o   (resp_tag_o),
        .resp_data_o  (resp_data_o)
    );

    // R2: both arrays are enabled in the same cycle
    a_r2_oe_lockstep: assert property (@(posedge clk_i) disable iff (rst_i)
        tag_oe_n_o == dat_oe_n_o);

    // R3: a three-stage response follows an issue cycle three edges back
    a_r3_pipe3_latency: assert property (@(posedge clk_i) disable iff (rst_i)
        (resp_valid_o && mode_q == RD_PIPE3) |-> !$past(tag_oe_n_o, 3));

    // R4: a two-stage response follows an issue cycle two edges back
    a_r4_pipe2_latency: assert property (@(posedge clk_i) disable iff (rst_i)
        (resp_valid_o && mode_q == RD_PIPE2) |-> !$past(tag_oe_n_o, 2));

endmodule

// File: tb/test_ecache_rd_seq.sv
module test_ecache_rd_seq;

    localparam int unsigned ADDR_W = 16;
    localparam int unsigned SUB_W  = 2;
    localparam int unsigned TAG_W  = 12;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned TA_W   = ADDR_W - SUB_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mode_sel = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              tag_oe_n, tag_we_n, dat_oe_n, dat_we_n;
    logic [TA_W-1:0]   tag_addr;
    logic [ADDR_W-1:0] dat_addr;
    logic [TAG_W-1:0]  tag_bus;
    logic [DATA_W-1:0] dat_bus;
    logic              resp_valid;
    logic [TAG_W-1:0]  resp_tag;
    logic [DATA_W-1:0] resp_data;

    always #4 clk = ~clk;   // 125 MHz

    ecache_rd_seq #(
        .ADDR_W (ADDR_W), .SUB_W (SUB_W), .TAG_W (TAG_W), .DATA_W (DATA_W)
    ) i_ecache_rd_seq (
        .clk_i (clk), .rst_i (rst), .mode_sel_i (mode_sel),
        .req_valid_i (req_valid), .req_ready_o (req_ready), .req_addr_i (req_addr),
        .tag_oe_n_o (tag_oe_n), .tag_we_n_o (tag_we_n), .tag_addr_o (tag_addr),
        .tag_rdata_i (tag_bus),
        .dat_oe_n_o (dat_oe_n), .dat_we_n_o (dat_we_n), .dat_addr_o (dat_addr),
        .dat_rdata_i (dat_bus),
        .resp_valid_o (resp_valid), .resp_tag_o (resp_tag), .resp_data_o (resp_data)
    );

    function automatic logic [TAG_W-1:0] tag_fn(logic [TA_W-1:0] a);
        return a[TAG_W-1:0] ^ {a[TA_W-1:TAG_W], 10'h2A5};
    endfunction

    function automatic logic [DATA_W-1:0] dat_fn(logic [ADDR_W-1:0] a);
        return {~a, a} ^ 32'h1357_9BDF;
    endfunction

    // Bench model of the design's mode: 0 three-stage, 1 two-stage.
    bit tb_mode = 1'b0;

    // Behavioural synchronous SRAMs: address registered on the edge after
    // the enable, then an optional output register for the three-stage mode.
    logic            t1v = 1'b0, t2v = 1'b0, d1v = 1'b0, d2v = 1'b0;
    logic [TA_W-1:0] t1a = '0, t2a = '0;
    logic [ADDR_W-1:0] d1a = '0, d2a = '0;
    always @(posedge clk) begin
        t1v <= !tag_oe_n; t1a <= tag_addr; t2v <= t1v; t2a <= t1a;
        d1v <= !dat_oe_n; d1a <= dat_addr; d2v <= d1v; d2a <= d1a;
    end
    assign tag_bus = tb_mode ? (t1v ? tag_fn(t1a) : '0) : (t2v ? tag_fn(t2a) : '0);
    assign dat_bus = tb_mode ? (d1v ? dat_fn(d1a) : '0) : (d2v ? dat_fn(d2a) : '0);

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [ADDR_W-1:0] a;
        int                due;
        string             rq;
    } exp_t;
    exp_t q[$];

    int    n_chk = 0, n_bad = 0;
    bit    mon_en = 1'b0;
    bit    is_issue = 1'b0;
    logic [ADDR_W-1:0] is_addr = '0;
    string rq_override = "";
    bit    done = 1'b0;

    task automatic check(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", rq, what, act, exp, cyc);
        end
    endtask

    function automatic int outstanding();
        int n = 0;
        foreach (q[i]) if (q[i].due > cyc) n++;
        return n;
    endfunction

    // One clock of stimulus: optional request with the given mode input.
    task automatic step(bit v, logic [ADDR_W-1:0] a, bit m);
        bit acc;
        int lat;
        @(negedge clk);
        mode_sel  = m;
        req_valid = v;
        req_addr  = a;
        if (outstanding() == 0) tb_mode = m;   // R7 model: mode follows input only when idle
        #1;
        acc = v && req_ready;
        if (v) check(req_ready, "R5", "ready under load", {63'd0, req_ready}, 64'd1);
        if (acc) begin
            exp_t e;
            lat  = tb_mode ? 2 : 3;
            e.a  = a;
            e.due = cyc + 1 + lat;
            e.rq = (rq_override != "") ? rq_override : (tb_mode ? "R4" : "R3");
            q.push_back(e);
        end
        @(posedge clk);
        #1;
        is_issue = acc;
        is_addr  = a;
    endtask

    // Port monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (mon_en) begin
            if (is_issue) begin
                check(!tag_oe_n && !dat_oe_n, "R2", "enables low after accept",
                      {62'd0, tag_oe_n, dat_oe_n}, 64'd0);
                check(tag_addr == is_addr[ADDR_W-1:SUB_W], "R2", "tag address",
                      64'(tag_addr), 64'(is_addr[ADDR_W-1:SUB_W]));
                check(dat_addr == is_addr, "R2", "data address", 64'(dat_addr), 64'(is_addr));
            end else begin
                check(tag_oe_n && dat_oe_n, "R2", "enables high when idle",
                      {62'd0, tag_oe_n, dat_oe_n}, 64'd3);
            end
            check(tag_we_n && dat_we_n, "R6", "write strobes",
                  {62'd0, tag_we_n, dat_we_n}, 64'd3);
            while (q.size() > 0 && q[0].due < cyc) begin
                check(1'b0, q[0].rq, "response missing", 64'(cyc), 64'(q[0].due));
                void'(q.pop_front());
            end
            if (resp_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R9", "unexpected response", 64'd1, 64'd0);
                end else begin
                    check(q[0].due == cyc, q[0].rq, "response cycle", 64'(cyc), 64'(q[0].due));
                    check(resp_tag == tag_fn(q[0].a[ADDR_W-1:SUB_W]), "R8", "response tag",
                          64'(resp_tag), 64'(tag_fn(q[0].a[ADDR_W-1:SUB_W])));
                    check(resp_data == dat_fn(q[0].a), "R8", "response data",
                          64'(resp_data), 64'(dat_fn(q[0].a)));
                    void'(q.pop_front());
                end
            end
        end
    end

    task automatic drain(bit m);
        for (int i = 0; i < 6; i++) step(1'b0, '0, m);
        check(q.size() == 0, "R8", "all responses delivered", 64'(q.size()), 64'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(tag_oe_n && dat_oe_n, "R1", "enables in reset", {62'd0, tag_oe_n, dat_oe_n}, 64'd3);
        check(tag_we_n && dat_we_n, "R1", "strobes in reset", {62'd0, tag_we_n, dat_we_n}, 64'd3);
        check(!resp_valid, "R1", "resp_valid in reset", {63'd0, resp_valid}, 64'd0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(req_ready, "R1", "ready after reset", {63'd0, req_ready}, 64'd1);
        check(!resp_valid, "R1", "resp_valid after reset", {63'd0, resp_valid}, 64'd0);
        mon_en = 1'b1;
    endtask

    task automatic t_pipe3_burst();
        for (int i = 0; i < 8; i++) step(1'b1, 16'h1000 + 16'(i * 5), 1'b0);
        drain(1'b0);
    endtask

    task automatic t_pipe2_burst();
        for (int i = 0; i < 8; i++) step(1'b1, 16'hA3C0 + 16'(i * 7), 1'b1);
        drain(1'b1);
    endtask

    task automatic t_sparse();
        for (int i = 0; i < 6; i++) step(i % 2 == 0, 16'h5551 + 16'(i * 3), 1'b1);
        drain(1'b1);
        for (int i = 0; i < 7; i++) step(i % 3 != 1, 16'hFFF0 + 16'(i), 1'b0);
        drain(1'b0);
    endtask

    task automatic t_mode_busy();
        rq_override = "R7";
        step(1'b1, 16'h2222, 1'b0);
        step(1'b1, 16'h2223, 1'b0);
        step(1'b1, 16'h2224, 1'b1);   // mode flipped while busy: ignored
        step(1'b1, 16'h2225, 1'b1);
        step(1'b0, 16'h0000, 1'b1);
        step(1'b0, 16'h0000, 1'b1);
        step(1'b0, 16'h0000, 1'b1);
        check(tb_mode == 1'b0, "R7", "bench mode held while busy", 64'(tb_mode), 64'd0);
        drain(1'b1);                  // now idle: two-stage takes effect
        step(1'b1, 16'h3330, 1'b1);
        step(1'b1, 16'h3331, 1'b0);   // flip back while busy: ignored
        drain(1'b0);
        rq_override = "";
    endtask

    task automatic t_reset_mid();
        step(1'b1, 16'h7000, 1'b0);
        step(1'b1, 16'h7001, 1'b0);
        @(negedge clk);
        req_valid = 1'b0;
        mon_en = 1'b0;
        rst = 1'b1;
        q.delete();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        is_issue = 1'b0;
        mon_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            step(1'b0, '0, 1'b0);
            check(!resp_valid, "R9", "no response after reset", {63'd0, resp_valid}, 64'd0);
        end
        step(1'b1, 16'h7100, 1'b0);
        drain(1'b0);
    endtask

    initial begin
        t_reset();
        t_pipe3_burst();
        t_pipe2_burst();
        t_sparse();
        t_mode_busy();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule